// File: doc/BRIEF.md
# CAN Nominal Bit Timing and Bus Sampler

This block sits behind the baud-rate prescaler of a CAN receiver. It uses a one-cycle time-quantum enable to divide each nominal bit into three parts: a one-quantum synchronization segment, phase segment 1 and phase segment 2. It samples the receive line at the boundary between the two phase segments. It puts out a strobe at the start of every bit, a strobe when a sampled bit value is ready, the sampled value itself, and a flag that is raised when the current timing setup cannot be used.

An 8-bit setup word selects the two phase-segment lengths and the sampling mode. In single mode the line is read once per bit. In triple mode it is read on three consecutive quanta and the bit value is the majority of the three reads. Triple mode also adds two quanta to phase segment 1. The setup word can be loaded only while the software-initialization input is high. The bit timer is held idle while that input is high and while the setup is invalid. The prescale value comes in as an input and is used only for the validity check.

Top module: `can_bit_sampler`

## Requirements
- R1: The setup word resets to 8'h00 and reads back on `cfg_rd`. Bit 7 selects the mode (0 = single, 1 = triple). Bits 6:4 hold the phase-2 code and bits 3:0 hold the phase-1 code.
- R2: A write with `cfg_we` high loads `cfg_wdata` one cycle later, but only when `sw_init` is high. A write while `sw_init` is low leaves the word unchanged.
- R3: `cfg_bad` is high whenever the phase-1 code or the phase-2 code is 0.
- R4: `cfg_bad` is high when triple mode is selected and `presc` is below 4. With a prescale of 4 or more and valid codes, `cfg_bad` is low.
- R5: A bit lasts 1 + L1 + L2 quanta. L2 is the phase-2 code plus 1 (2..8). L1 is the phase-1 code plus 1 (2..16), plus 2 more in triple mode.
- R6: `bit_start` pulses for one cycle, one clock after the `tq_en` cycle that processes quantum 0 (the synchronization segment) of each bit.
- R7: In single mode, the line is read on the `tq_en` cycle of quantum index L1 (the last phase-1 quantum). `rx_bit` takes that value and `sample_stb` pulses one clock later.
- R8: In triple mode, the line is read on quantum indices L1-2, L1-1 and L1. `rx_bit` becomes the majority of the three reads, and `sample_stb` pulses one clock after the third read.
- R9: While `sw_init` or `cfg_bad` is high, the quantum counter is held at the start of a bit and neither strobe pulses. The first quantum after release starts a new bit.
- R10: The quantum count advances only on cycles with `tq_en` high. Idle cycles between quanta change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_init | input | 1 | Software initialization: unlocks the setup word and holds the timer |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_wdata | input | 8 | Setup word write data |
| presc | input | 6 | Current baud-rate prescale value |
| tq_en | input | 1 | One-cycle pulse per time quantum |
| rx_in | input | 1 | Receive line |
| cfg_rd | output | 8 | Setup word readback |
| sample_stb | output | 1 | Pulses when a new sampled bit is ready |
| rx_bit | output | 1 | Sampled bit value |
| bit_start | output | 1 | Pulses at the start of each bit |
| cfg_bad | output | 1 | Setup cannot be used |

## Verification
The assertions check, on every cycle, that the setup word stays frozen outside initialization and that the quantum counter never passes the last quantum of the bit. They also check that the counter does not move on idle cycles, that no strobe follows a held cycle, and that the two strobes never coincide. Only the bench scenarios can show the exact cycle of each strobe for a given pair of segment codes. The same holds for the majority result when one or two of the three reads disagree, and for the minimum and maximum segment lengths in both modes. The bench covers these with a timestamped scoreboard.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the CAN bit-timing sampler.
// Assumes: the mode field is one bit; majority is of exactly three reads.
package can_bt_pkg;

    typedef enum logic {
        SMP_SINGLE = 1'b0,
        SMP_TRIPLE = 1'b1
    } smp_mode_e;

    // Majority of three reads.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_bt_cfg.sv
`timescale 1ns/1ps
// Setup-word register and decoder.
// Holds {mode, phase-2 code, phase-1 code}. It loads only while init is high,
// turns the codes into quantum lengths (code + 1) and flags unusable setups.
// Assumes: CNT_W is wide enough for the largest bit length.
module can_bt_cfg
    import can_bt_pkg::*;
#(
    parameter int PS1_W      = 4,
    parameter int PS2_W      = 3,
    parameter int PRESC_W    = 6,
    parameter int MIN_PRESC3 = 4,
    parameter int CNT_W      = 5,
    localparam int CFG_W     = 1 + PS2_W + PS1_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [CNT_W-1:0] ps1_len_o,
    output logic [CNT_W-1:0] ps2_len_o,
    output logic             triple_o,
    output logic             bad_o
);

    logic [CFG_W-1:0] cfg_q;
    logic [PS1_W-1:0] ps1_code;
    logic [PS2_W-1:0] ps2_code;
    smp_mode_e        mode;

    // Setup word: reset to zero, load only during initialization.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (init_i && we_i)
            cfg_q <= wdata_i;
    end

    // Field split and length decode.
    always_comb begin
        ps1_code  = cfg_q[PS1_W-1:0];
        ps2_code  = cfg_q[CFG_W-2:PS1_W];
        mode      = smp_mode_e'(cfg_q[CFG_W-1]);
        triple_o  = (mode == SMP_TRIPLE);
        ps1_len_o = CNT_W'(ps1_code) + CNT_W'(1);
        ps2_len_o = CNT_W'(ps2_code) + CNT_W'(1);
    end

    // Validity: zero codes, or triple mode with too small a prescale.
    always_comb begin
        bad_o = (ps1_code == '0) || (ps2_code == '0) ||
                (triple_o && (presc_i < PRESC_W'(MIN_PRESC3)));
    end

    assign cfg_o = cfg_q;

    // R2: setup word cannot move outside initialization.
    p_frozen_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> $stable(cfg_q));

endmodule

// File: rtl/can_bt_timer.sv
`timescale 1ns/1ps
// Quantum counter for one nominal bit.
// Index 0 is the synchronization segment, 1..L1 is phase 1 and
// L1+1..L1+L2 is phase 2. It marks the read window before the sample point.
// Assumes: lengths are stable while hold_i is low.
module can_bt_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             tq_en_i,
    input  logic [CNT_W-1:0] ps1_len_i,
    input  logic [CNT_W-1:0] ps2_len_i,
    input  logic             triple_i,
    output logic             bit_stb_o,
    output logic             tap_o,
    output logic             final_o
);

    localparam logic [CNT_W-1:0] EXTRA = CNT_W'(2);

    logic [CNT_W-1:0] q;
    logic [CNT_W-1:0] ps1_eff;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] win_lo;
    logic             live;

    // Effective phase-1 end, last index and read-window start.
    always_comb begin
        ps1_eff = ps1_len_i + (triple_i ? EXTRA : '0);
        last_q  = ps1_eff + ps2_len_i;
        win_lo  = triple_i ? (ps1_eff - EXTRA) : ps1_eff;
        live    = tq_en_i && !hold_i;
        tap_o   = live && (q >= win_lo) && (q <= ps1_eff);
        final_o = live && (q == ps1_eff);
    end

    // Quantum index: cleared on hold, wraps after the last quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i)
            q <= '0;
        else if (tq_en_i)
            q <= (q == last_q) ? '0 : q + CNT_W'(1);
    end

    // Bit-start strobe, one clock after the sync quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_stb_o <= 1'b0;
        else
            bit_stb_o <= live && (q == '0);
    end

    // R5: index never passes the last quantum of the bit.
    p_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q <= last_q);

    // R10: no quantum, no movement.
    p_idle_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tq_en_i && !hold_i) |=> $stable(q));

    // R9: a held cycle starts no bit.
    p_held_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !bit_stb_o);

endmodule

// File: rtl/can_bt_vote.sv
`timescale 1ns/1ps
// Bus reader. It keeps the reads taken in the window, then produces the bit
// at the sample point: the current read in single mode, the majority of the
// last three in triple mode.
// Assumes: final_i is only high on a cycle that also has tap_i high.
module can_bt_vote
    import can_bt_pkg::*;
#(
    parameter int HIST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_i,
    input  logic final_i,
    input  logic triple_i,
    input  logic rx_i,
    output logic bit_o,
    output logic stb_o
);

    logic [HIST-1:0] hist;

    // Read history: a shift register moved on each window quantum.
    for (genvar i = 0; i < HIST; i++) begin : g_hist
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist[0] <= 1'b0;
                else if (tap_i)
                    hist[0] <= rx_i;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist[i] <= 1'b0;
                else if (tap_i)
                    hist[i] <= hist[i-1];
            end
        end
    end

    // Bit value and strobe at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= final_i;
            if (final_i)
                bit_o <= triple_i ? maj3(hist[1], hist[0], rx_i) : rx_i;
        end
    end

    // R7: single mode takes the line value at the sample point.
    p_single_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (final_i && !triple_i) |=> (stb_o && bit_o == $past(rx_i)));

    // R8: three reads that agree give that value.
    p_triple_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (final_i && triple_i && hist[1] == rx_i && hist[0] == rx_i) |=> (bit_o == $past(rx_i)));

endmodule

// File: rtl/can_bit_sampler.sv
`timescale 1ns/1ps
// CAN nominal bit timing and bus sampler, top level.
// Ties the setup register, the quantum counter and the bus reader together.
// The timer is held while initialization is on or the setup is invalid.
// Assumes: tq_en is a one-cycle pulse from an external prescaler.
module can_bit_sampler #(
    parameter int PS1_W      = 4,
    parameter int PS2_W      = 3,
    parameter int PRESC_W    = 6,
    parameter int MIN_PRESC3 = 4,
    localparam int CFG_W     = 1 + PS2_W + PS1_W,
    localparam int MAX_BIT   = 1 + (1 << PS1_W) + 2 + (1 << PS2_W),
    localparam int CNT_W     = $clog2(MAX_BIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_init,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [PRESC_W-1:0] presc,
    input  logic               tq_en,
    input  logic               rx_in,
    output logic [CFG_W-1:0]   cfg_rd,
    output logic               sample_stb,
    output logic               rx_bit,
    output logic               bit_start,
    output logic               cfg_bad
);

    logic [CNT_W-1:0] ps1_len;
    logic [CNT_W-1:0] ps2_len;
    logic             triple;
    logic             hold;
    logic             tap;
    logic             final_tap;

    can_bt_cfg #(
        .PS1_W(PS1_W), .PS2_W(PS2_W), .PRESC_W(PRESC_W),
        .MIN_PRESC3(MIN_PRESC3), .CNT_W(CNT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .init_i(sw_init), .we_i(cfg_we),
        .wdata_i(cfg_wdata), .presc_i(presc), .cfg_o(cfg_rd),
        .ps1_len_o(ps1_len), .ps2_len_o(ps2_len), .triple_o(triple),
        .bad_o(cfg_bad)
    );

    // Hold the timer during initialization or with an unusable setup.
    assign hold = sw_init || cfg_bad;

    can_bt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .tq_en_i(tq_en),
        .ps1_len_i(ps1_len), .ps2_len_i(ps2_len), .triple_i(triple),
        .bit_stb_o(bit_start), .tap_o(tap), .final_o(final_tap)
    );

    can_bt_vote #(.HIST(2)) u_vote (
        .clk(clk), .rst_n(rst_n), .tap_i(tap), .final_i(final_tap),
        .triple_i(triple), .rx_i(rx_in), .bit_o(rx_bit), .stb_o(sample_stb)
    );

    // R6: the two strobes never share a cycle.
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_start, sample_stb}));

    // R9: no sample follows a held cycle.
    p_held_nosample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !sample_stb);

endmodule

// File: tb/test_can_bit_sampler.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues timestamped expected strobes and the
// monitor pops and compares them as the design produces them.
module test_can_bit_sampler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_init = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [5:0] presc = 6'd8;
    logic       tq_en = 1'b0;
    logic       rx_in = 1'b0;
    logic [7:0] cfg_rd;
    logic       sample_stb, rx_bit, bit_start, cfg_bad;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    int    e_kind[$];
    int    e_val[$];
    int    e_cyc[$];
    string e_req[$];

    can_bit_sampler i_can_bit_sampler (
        .clk(clk), .rst_n(rst_n), .sw_init(sw_init), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .presc(presc), .tq_en(tq_en), .rx_in(rx_in),
        .cfg_rd(cfg_rd), .sample_stb(sample_stb), .rx_bit(rx_bit),
        .bit_start(bit_start), .cfg_bad(cfg_bad)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int val, input int at, input string req);
        e_kind.push_back(kind);
        e_val.push_back(val);
        e_cyc.push_back(at);
        e_req.push_back(req);
    endtask

    // Monitor: every strobe must match the next queued item in kind, cycle and value.
    task automatic observe(input int kind, input int val);
        if (e_kind.size() == 0) begin
            check(0, "R9 unexpected strobe", kind, -1);
        end else begin
            int k = e_kind.pop_front();
            int v = e_val.pop_front();
            int c = e_cyc.pop_front();
            string r = e_req.pop_front();
            check(k == kind, {r, " kind"}, kind, k);
            check(c == cyc, {r, " cycle"}, cyc, c);
            if (kind == 1) check(v == val, {r, " value"}, val, v);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bit_start) observe(0, 0);
            if (sample_stb) observe(1, int'(rx_bit));
        end
    end

    task automatic write_cfg(input logic [7:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_quanta(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tq_en = 1'b1; rx_in = i[0];
            @(negedge clk); tq_en = 1'b0;
        end
    endtask

    // Driver: plays nb bits with the given codes and queues the expected strobes.
    task automatic run_bits(input int nb, input int c1, input int c2, input bit smp);
        int ps1e = c1 + 1 + (smp ? 2 : 0);
        int tot  = 1 + ps1e + c2 + 1;
        for (int b = 0; b < nb; b++) begin
            logic base = logic'(((b * 5) >> 1) & 1);
            int   g    = b % 3;
            logic expv = (smp && g == 2) ? ~base : base;
            for (int q = 0; q < tot; q++) begin
                logic v = ~base;
                if (smp) begin
                    if (q >= ps1e - 2 && q <= ps1e) v = base;
                    if (g >= 1 && q == ps1e - 2) v = ~base;
                    if (g == 2 && q == ps1e - 1) v = ~base;
                end else if (q == ps1e) begin
                    v = base;
                end
                @(negedge clk);
                tq_en = 1'b1; rx_in = v;
                // R6 on the first bit; the spacing of later starts is R5.
                if (q == 0) push(0, 0, cyc + 1, (b == 0) ? "R6" : "R5");
                if (q == ps1e) push(1, int'(expv), cyc + 1, smp ? "R8" : "R7");
                @(negedge clk);
                tq_en = 1'b0; rx_in = ~v;
                // R10: irregular idle gaps between quanta.
                repeat ((q % 4 == 3) ? 5 : 1) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        check(e_kind.size() == 0, "R5 pending strobes", e_kind.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rd == 8'h00, "R1 reset word", cfg_rd, 0);
        check(cfg_bad == 1'b1, "R3 zero codes after reset", cfg_bad, 1);
        pulse_quanta(6);                       // R9: invalid setup, no strobes

        write_cfg(8'h35);                      // R2: locked outside initialization
        check(cfg_rd == 8'h00, "R2 write ignored", cfg_rd, 0);

        sw_init = 1'b1;
        write_cfg(8'h35);
        check(cfg_rd == 8'h35, "R1 loaded word", cfg_rd, 8'h35);
        check(cfg_bad == 1'b0, "R3 valid codes", cfg_bad, 0);
        pulse_quanta(5);                       // R9: held during initialization
        sw_init = 1'b0;
        run_bits(6, 5, 3, 1'b0);               // single mode, bit of 11 quanta

        sw_init = 1'b1;
        write_cfg(8'h91);
        presc = 6'd3;
        @(negedge clk);
        check(cfg_bad == 1'b1, "R4 triple with prescale 3", cfg_bad, 1);
        presc = 6'd4;
        @(negedge clk);
        check(cfg_bad == 1'b0, "R4 triple with prescale 4", cfg_bad, 0);
        sw_init = 1'b0;
        run_bits(6, 1, 1, 1'b1);               // triple mode, shortest segments

        presc = 6'd2;                          // R9: bad by prescale while running
        pulse_quanta(4);
        check(cfg_bad == 1'b1, "R4 prescale drop", cfg_bad, 1);
        presc = 6'd4;

        sw_init = 1'b1;
        write_cfg(8'h05);
        check(cfg_bad == 1'b1, "R3 phase-2 code zero", cfg_bad, 1);
        write_cfg(8'h30);
        check(cfg_bad == 1'b1, "R3 phase-1 code zero", cfg_bad, 1);
        write_cfg(8'h7F);
        sw_init = 1'b0;
        run_bits(3, 15, 7, 1'b0);              // single mode, longest bit

        sw_init = 1'b1;
        write_cfg(8'hFF);
        sw_init = 1'b0;
        run_bits(6, 15, 7, 1'b1);              // triple mode, longest bit

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        if (!done) begin
            check(0, "R5 watchdog", cyc, 0);
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule